// File: doc/BRIEF.md
# Predicated Vector Float-to-Integer Truncating Converter

This block takes one packed vector and rewrites each lane from IEEE floating point (half, single or double) to a signed two's-complement integer of 32 or 64 bits. The result is always rounded toward zero. A per-byte predicate mask controls which lanes are converted. Lanes that are not selected keep the contents they had in the incoming vector, so the converter can sit in an execution pipe that merges its result back into the destination register.

When the source and result element sizes differ, each lane is as wide as the larger of the two. The narrower value sits in the lane's low bits. If the source is the narrower type, the upper bits of each lane are ignored. If the result is the narrower type, it is sign-extended to fill the lane. The conversion is one combinational stage per lane followed by one register stage. An operation is offered with `in_valid`, and `out_valid` marks its result exactly one cycle later. Two sticky-free flags summarise the operation: invalid (NaN, infinity or out-of-range input) and inexact (a nonzero fraction was discarded). The block changes no condition flags.

Top module: `fcvt_vec_trunc`

## Requirements
- R1: An active lane holds the integer part of its input with the fraction dropped, toward zero, for both signs (2.5 gives 2, -2.5 gives -2, -7.5 gives -7, 0.75 gives 0).
- R2: A lane whose predicate bit is clear passes its `vec_in` bits unchanged to `vec_out`, and its value never contributes to either flag.
- R3: Lane e is active when `pred[e*B]` is set, where B is the lane width in bytes (4 or 8). All other predicate bits have no effect.
- R4: `src_fmt` encodes 0 = half, 1 = single, 2 = double. `dst_wide` encodes 0 = 32-bit result, 1 = 64-bit result. The lane is 64 bits when the source is double or `dst_wide` is 1, and 32 bits otherwise. There are VLEN/lanewidth lanes, with lane e at bits [e*W +: W].
- R5: A half or single source is read from the low 16 or 32 bits of its lane, and the bits above are ignored.
- R6: A 32-bit result in a 64-bit lane is sign-extended over bits [63:32] of that lane.
- R7: A finite value outside the result range saturates to the most positive or most negative integer and raises `flag_invalid`. Plus and minus infinity saturate the same way.
- R8: A NaN in an active lane produces 0 and raises `flag_invalid`.
- R9: `flag_inexact` is set when any active lane that is not invalid dropped a nonzero fraction. This includes denormals, which convert to 0. Zero of either sign is exact.
- R10: With no active lane, `vec_out` equals `vec_in` and both flags are clear.
- R11: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Outputs change only on an accepted operation. Reset clears `out_valid`, `vec_out` and both flags.
- R12: The most negative integer of the result width (-2^31 or -2^63), given exactly, converts without raising `flag_invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered this cycle |
| src_fmt | input | 2 | Source format: 0 half, 1 single, 2 double |
| dst_wide | input | 1 | Result width: 0 for 32 bits, 1 for 64 bits |
| pred | input | VLEN/8 | Predicate, one bit per byte |
| vec_in | input | VLEN | Source values and merge data |
| out_valid | output | 1 | Result present |
| vec_out | output | VLEN | Converted and merged vector |
| flag_invalid | output | 1 | Some active lane was NaN, infinite or out of range |
| flag_inexact | output | 1 | Some active, valid lane dropped a fraction |

## Verification
The checks assume that `src_fmt` never carries the unused code 3 while `in_valid` is high. The stimulus table uses only the three legal codes.

The per-lane checks assume that every lane converter sees a well-formed source field. Because of this, the bench loads upper lane bits with unrelated patterns only in modes where those bits must be ignored.

Merge checks compare each 32-bit slice of the output with the input slice from the previous cycle. The bench therefore holds `vec_in` steady until the operation has been registered.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    typedef enum logic [1:0] {
        SRC_HALF   = 2'd0,
        SRC_SINGLE = 2'd1,
        SRC_DOUBLE = 2'd2
    } src_fmt_e;

    localparam int SIG_W    = 53;
    localparam int FRAC_TOP = SIG_W - 1;
    localparam int EXP_W    = 13;

    // Common unpacked form: value = sig * 2^(exp_unb - FRAC_TOP)
    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_inf;
        logic             is_tiny;
        logic [EXP_W-1:0] exp_unb;
        logic [SIG_W-1:0] sig;
    } fp_norm_t;

    typedef struct packed {
        logic [63:0] value;
        logic        invalid;
        logic        inexact;
    } conv_res_t;

    localparam logic [63:0] LIM_WIDE   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] LIM_NARROW = 64'h0000_0000_8000_0000;
    localparam logic [63:0] MAX_WIDE   = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MIN_WIDE   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAX_NARROW = 64'h0000_0000_7FFF_FFFF;
    localparam logic [63:0] MIN_NARROW = 64'hFFFF_FFFF_8000_0000;

endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  logic [63:0] raw,
    input  src_fmt_e    fmt,
    output fp_norm_t    norm
);

    logic [10:0]      exp_field;
    logic [10:0]      exp_all_ones;
    logic [51:0]      man_field;
    logic [EXP_W-1:0] bias;
    logic             sign_bit;

    always_comb begin
        case (fmt)
            SRC_HALF: begin
                sign_bit     = raw[15];
                exp_field    = {6'b0, raw[14:10]};
                man_field    = {raw[9:0], 42'b0};
                exp_all_ones = 11'h01F;
                bias         = 13'd15;
            end
            SRC_SINGLE: begin
                sign_bit     = raw[31];
                exp_field    = {3'b0, raw[30:23]};
                man_field    = {raw[22:0], 29'b0};
                exp_all_ones = 11'h0FF;
                bias         = 13'd127;
            end
            default: begin
                sign_bit     = raw[63];
                exp_field    = raw[62:52];
                man_field    = raw[51:0];
                exp_all_ones = 11'h7FF;
                bias         = 13'd1023;
            end
        endcase

        norm.sign    = sign_bit;
        norm.is_nan  = (exp_field == exp_all_ones) && (man_field != '0);
        norm.is_inf  = (exp_field == exp_all_ones) && (man_field == '0);
        norm.is_tiny = (exp_field == '0);
        norm.exp_unb = {2'b0, exp_field} - bias;
        norm.sig     = {(exp_field != '0), man_field};
    end

endmodule

// File: rtl/fcvt_trunc.sv
module fcvt_trunc
    import fcvt_pkg::*;
(
    input  fp_norm_t  norm,
    input  logic      dst_wide,
    output conv_res_t res
);

    logic signed [EXP_W-1:0] e;
    logic [63:0] sig_x;
    logic [63:0] mag;
    logic [63:0] frac_mask;
    logic [63:0] lim;
    logic [63:0] twos;
    logic [5:0]  sh;
    logic        lost;
    logic        ovf;

    always_comb begin
        e         = $signed(norm.exp_unb);
        sig_x     = {11'b0, norm.sig};
        mag       = '0;
        frac_mask = '0;
        sh        = '0;
        lost      = 1'b0;
        ovf       = 1'b0;

        if (norm.is_nan) begin
            lost = 1'b0;
        end else if (norm.is_inf) begin
            ovf = 1'b1;
        end else if (norm.is_tiny || (e < 13'sd0)) begin
            lost = |norm.sig;
        end else if (e > 13'sd63) begin
            ovf = 1'b1;
        end else if (e <= 13'sd52) begin
            sh        = 6'(13'sd52 - e);
            mag       = sig_x >> sh;
            frac_mask = (64'd1 << sh) - 64'd1;
            lost      = |(sig_x & frac_mask);
        end else begin
            mag = sig_x << 6'(e - 13'sd52);
        end

        lim = dst_wide ? LIM_WIDE : LIM_NARROW;
        if (!norm.is_nan && !ovf) begin
            if (norm.sign ? (mag > lim) : (mag >= lim)) begin
                ovf = 1'b1;
            end
        end

        twos = norm.sign ? (64'd0 - mag) : mag;

        if (norm.is_nan) begin
            res.value = '0;
        end else if (ovf) begin
            if (norm.sign) res.value = dst_wide ? MIN_WIDE : MIN_NARROW;
            else           res.value = dst_wide ? MAX_WIDE : MAX_NARROW;
        end else if (dst_wide) begin
            res.value = twos;
        end else begin
            res.value = {{32{twos[31]}}, twos[31:0]};
        end

        res.invalid = norm.is_nan | ovf;
        res.inexact = lost & ~res.invalid;
    end

endmodule

// File: rtl/fcvt_slot.sv
module fcvt_slot
    import fcvt_pkg::*;
(
    input  logic [63:0] raw,
    input  src_fmt_e    fmt,
    input  logic        dst_wide,
    output logic [63:0] value,
    output logic        invalid,
    output logic        inexact
);

    fp_norm_t  norm;
    conv_res_t res;

    fcvt_unpack u_unpack (
        .raw  (raw),
        .fmt  (fmt),
        .norm (norm)
    );

    fcvt_trunc u_trunc (
        .norm     (norm),
        .dst_wide (dst_wide),
        .res      (res)
    );

    assign value   = res.value;
    assign invalid = res.invalid;
    assign inexact = res.inexact;

    always_comb begin
        if (norm.is_nan) begin
            AST_NAN_GIVES_ZERO: assert (res.invalid && (res.value == '0)); // R8
        end
        if (!res.invalid && res.value[63]) begin
            AST_SIGN_PRESERVED: assert (norm.sign); // R1
        end
        if (norm.is_tiny) begin
            AST_TINY_IS_ZERO: assert ((res.value == '0) && !res.invalid); // R9
        end
        if (!dst_wide) begin
            AST_NARROW_SEXT: assert (res.value[63:32] == {32{res.value[31]}}); // R6
        end
    end

endmodule

// File: rtl/fcvt_vec_trunc.sv
module fcvt_vec_trunc
    import fcvt_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        src_fmt,
    input  logic              dst_wide,
    input  logic [VLEN/8-1:0] pred,
    input  logic [VLEN-1:0]   vec_in,
    output logic              out_valid,
    output logic [VLEN-1:0]   vec_out,
    output logic              flag_invalid,
    output logic              flag_inexact
);

    localparam int SLOT_W     = 32;
    localparam int NSLOT      = VLEN / SLOT_W;
    localparam int NARROW_BYT = SLOT_W / 8;
    localparam int WIDE_BYT   = 2 * NARROW_BYT;

    typedef struct packed {
        logic            valid;
        logic            inv;
        logic            inx;
        logic [VLEN-1:0] vec;
    } state_t;

    src_fmt_e fmt_e;
    logic     wide_lane;
    logic     any_on;

    logic [NSLOT-1:0][63:0]       slot_raw;
    logic [NSLOT-1:0][63:0]       slot_res;
    logic [NSLOT-1:0][SLOT_W-1:0] slot_word;
    logic [NSLOT-1:0]             slot_on;
    logic [NSLOT-1:0]             slot_use;
    logic [NSLOT-1:0]             slot_inv;
    logic [NSLOT-1:0]             slot_inx;
    logic [VLEN-1:0]              merged;

    state_t st_d, st_q;

    assign fmt_e     = src_fmt_e'(src_fmt);
    assign wide_lane = (fmt_e == SRC_DOUBLE) | dst_wide;
    assign any_on    = |slot_on;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign slot_on[k] = wide_lane ? pred[(k/2)*WIDE_BYT] : pred[k*NARROW_BYT];

        if (k % 2 == 0) begin : g_even
            assign slot_raw[k] = !any_on ? 64'd0 :
                                 wide_lane ? vec_in[(k/2)*64 +: 64]
                                           : {32'b0, vec_in[k*SLOT_W +: SLOT_W]};
            assign slot_word[k] = slot_res[k][SLOT_W-1:0];
            assign slot_use[k]  = slot_on[k];
        end else begin : g_odd
            assign slot_raw[k]  = !any_on ? 64'd0 : {32'b0, vec_in[k*SLOT_W +: SLOT_W]};
            assign slot_word[k] = wide_lane ? slot_res[k-1][63:32] : slot_res[k][SLOT_W-1:0];
            assign slot_use[k]  = slot_on[k] & ~wide_lane;

            AST_ODD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !wide_lane) |-> (slot_res[k][63:32] == {32{slot_res[k][31]}})); // R6
        end

        fcvt_slot u_slot (
            .raw      (slot_raw[k]),
            .fmt      (fmt_e),
            .dst_wide (dst_wide),
            .value    (slot_res[k]),
            .invalid  (slot_inv[k]),
            .inexact  (slot_inx[k])
        );

        assign merged[k*SLOT_W +: SLOT_W] = slot_on[k] ? slot_word[k]
                                                       : vec_in[k*SLOT_W +: SLOT_W];

        AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !slot_on[k]) |=>
            (vec_out[k*SLOT_W +: SLOT_W] == $past(vec_in[k*SLOT_W +: SLOT_W]))); // R2
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.vec = merged;
            st_d.inv = |(slot_inv & slot_use);
            st_d.inx = |(slot_inx & slot_use);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.valid;
    assign vec_out      = st_q.vec;
    assign flag_invalid = st_q.inv;
    assign flag_inexact = st_q.inx;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(vec_out) && $stable(flag_invalid)
                       && $stable(flag_inexact))); // R11
    AST_NONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (pred == '0)) |=>
        ((vec_out == $past(vec_in)) && !flag_invalid && !flag_inexact)); // R10
    AST_FMT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (src_fmt != 2'd3)); // R4

endmodule

// File: tb/tb_fcvt_vec_trunc.sv
`timescale 1ns/1ps
module tb_fcvt_vec_trunc;

    localparam int VLEN = 128;
    localparam int NT   = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [1:0]        src_fmt;
    logic              dst_wide;
    logic [VLEN/8-1:0] pred;
    logic [VLEN-1:0]   vec_in;
    logic              out_valid;
    logic [VLEN-1:0]   vec_out;
    logic              flag_invalid;
    logic              flag_inexact;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    fcvt_vec_trunc #(.VLEN(VLEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_fmt(src_fmt),
        .dst_wide(dst_wide), .pred(pred), .vec_in(vec_in), .out_valid(out_valid),
        .vec_out(vec_out), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    localparam logic [1:0] T_FMT [NT] = '{
        2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd0, 2'd0, 2'd1,
        2'd2, 2'd2, 2'd2, 2'd2, 2'd1, 2'd2, 2'd0, 2'd1 };
    localparam logic T_WIDE [NT] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
        1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0 };
    localparam logic [15:0] T_PRED [NT] = '{
        16'h1111, 16'h0101, 16'hEEEE, 16'h1111, 16'h1111, 16'h1111, 16'h0101, 16'h0101,
        16'h0101, 16'h0101, 16'h0100, 16'h0001, 16'h1111, 16'h1010, 16'h1000, 16'h0000 };
    localparam logic [127:0] T_VIN [NT] = '{
        128'hC0200000_40200000_3F400000_42C80000,
        128'h11111111_40400000_22222222_C0F00000,
        128'h4F800000_7FC00000_7F800000_3F800000,
        128'hCF000000_4EFFFFFF_3F800000_BF800000,
        128'h4F000000_FF800000_7F800000_7FC00000,
        128'hABCD4100_1234C200_FFFF7BFF_00003800,
        128'hDEADBEEFDEADC100_0123456789AB7C00,
        128'h555555554F800000_00000000C0200000,
        128'h41E65A0BC0000000_C004000000000000,
        128'hC3E0000000000000_41E65A0BC0000000,
        128'h43E0000000000000_0123456789ABCDEF,
        128'hFFF8000000000000_3FF8000000000000,
        128'h00000001_80000000_00000000_807FFFFF,
        128'h7FF8000000000000_7FF0000000000000,
        128'h7E007E00_7E007E00_3C003C00_3C003C00,
        128'h7FC00000_4F800000_C0200000_3F400000 };
    localparam logic [127:0] T_VOUT [NT] = '{
        128'hFFFFFFFE_00000002_00000000_00000064,
        128'h11111111_00000003_22222222_FFFFFFF9,
        128'h4F800000_7FC00000_7F800000_3F800000,
        128'h80000000_7FFFFF80_00000001_FFFFFFFF,
        128'h7FFFFFFF_80000000_7FFFFFFF_00000000,
        128'h00000002_FFFFFFFD_0000FFE0_00000000,
        128'hFFFFFFFFFFFFFFFE_7FFFFFFFFFFFFFFF,
        128'h0000000100000000_FFFFFFFFFFFFFFFE,
        128'h000000007FFFFFFF_FFFFFFFFFFFFFFFE,
        128'h8000000000000000_00000000B2D05E00,
        128'h7FFFFFFFFFFFFFFF_0123456789ABCDEF,
        128'hFFF8000000000000_0000000000000001,
        128'h00000000_00000000_00000000_00000000,
        128'h7FF8000000000000_7FF0000000000000,
        128'h00000000_7E007E00_3C003C00_3C003C00,
        128'h7FC00000_4F800000_C0200000_3F400000 };
    localparam logic T_INV [NT] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
        1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0 };
    localparam logic T_INX [NT] = '{
        1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,
        1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0 };

    function automatic string req_of(input int i);
        case (i)
            0:  return "R1";
            1:  return "R2";
            2:  return "R3";
            3:  return "R12";
            4:  return "R7";
            5:  return "R5";
            6:  return "R4";
            7:  return "R5";
            8:  return "R6";
            9:  return "R12";
            10: return "R7";
            11: return "R2";
            12: return "R9";
            13: return "R3";
            14: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input int i);
        in_valid = 1'b1;
        src_fmt  = T_FMT[i];
        dst_wide = T_WIDE[i];
        pred     = T_PRED[i];
        vec_in   = T_VIN[i];
    endtask

    task automatic check_vec(input int i);
        chk(req_of(i), $sformatf("vec %0d out_valid", i), 128'(out_valid), 128'd1);
        chk(req_of(i), $sformatf("vec %0d data", i), vec_out, T_VOUT[i]);
        chk(req_of(i), $sformatf("vec %0d invalid", i), 128'(flag_invalid), 128'(T_INV[i]));
        chk(req_of(i), $sformatf("vec %0d inexact", i), 128'(flag_inexact), 128'(T_INX[i]));
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        src_fmt  = 2'd0;
        dst_wide = 1'b0;
        pred     = '0;
        vec_in   = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "reset out_valid", 128'(out_valid), 128'd0);
        chk("R11", "reset data", vec_out, 128'd0);
        chk("R11", "reset flags", 128'({flag_invalid, flag_inexact}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk, back to back
        for (int i = 0; i < NT; i++) begin
            drive(i);
            @(negedge clk);
            check_vec(i);
        end

        // R11: idle cycles hold the last result
        in_valid = 1'b0;
        vec_in   = 128'hDEADDEAD_DEADDEAD_DEADDEAD_DEADDEAD;
        pred     = 16'hFFFF;
        @(negedge clk);
        chk("R11", "idle out_valid", 128'(out_valid), 128'd0);
        chk("R11", "idle hold data", vec_out, T_VOUT[NT-1]);
        @(negedge clk);
        chk("R11", "idle hold flags", 128'({flag_invalid, flag_inexact}), 128'd0);

        // R11: single op after gap, then valid drops next cycle
        drive(4);
        @(negedge clk);
        check_vec(4);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R11", "valid one cycle", 128'(out_valid), 128'd0);
        chk("R11", "hold invalid flag", 128'(flag_invalid), 128'd1);

        // R3: bit 12 selects lane 3 in 32-bit lanes only
        in_valid = 1'b1;
        src_fmt  = 2'd1;
        dst_wide = 1'b0;
        pred     = 16'h1000;
        vec_in   = 128'h40200000_40200000_40200000_40200000;
        @(negedge clk);
        chk("R3", "narrow lane3 only", vec_out, 128'h00000002_40200000_40200000_40200000);
        chk("R9", "narrow lane3 inexact", 128'(flag_inexact), 128'd1);

        // R11: asynchronous reset clears outputs mid-run
        in_valid = 1'b0;
        rst_n    = 1'b0;
        #1;
        chk("R11", "mid reset data", vec_out, 128'd0);
        chk("R11", "mid reset valid", 128'(out_valid), 128'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule